// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a bus-mapped interval timer. Software loads a throttle count and sets an enable bit. From then on, a counter advances once per bus clock. Each time the counter reaches the throttle value it wraps to zero and latches a pending flag. The interrupt request output is the pending flag gated by the enable bit, and it stays high until the CPU pulses the acknowledge input.

The register window is word addressed. Each word is 32 bits wide and is reached with separate write and read strobes. It holds these words:

| Word | Access | Contents |
|------|--------|----------|
| 0 | read/write | Control word, with the enable in bit 0 |
| 3 | read only | Status word: bit 0 is the pending flag, bit 1 is the live request level |
| 4 | read/write | Throttle value |
| 5 | read only | Live counter |
| 6 | read only | Bus clock period in nanoseconds, a constant fixed at build time |

Software divides one second by the word-6 value to get the tick rate. To retarget the timer, software clears the enable, writes the new throttle, and then sets the enable again. Every other word index, 7 and 11 included, reads as zero and ignores writes.

Top module: `pit_timer`

## Requirements
- R1: After reset, the enable, throttle, counter and pending flag are all zero and `irq` is low.
- R2: Bit 0 of word 0 is the enable and reads back in bit 0 of word 0. Writing word 0 with bit 0 clear stops the timer and holds the counter at zero.
- R3: While enabled with a nonzero throttle, the counter increases by one per clock, and word 5 returns its value. The counter never exceeds the throttle.
- R4: On the clock after the counter equals the throttle, the counter returns to zero and the pending flag is set. For throttle T, the first request appears T+1 clocks after the enabling write, and one follows every T+1 clocks after that.
- R5: A clock with `irq_ack` high clears the pending flag. If that clock also wraps the counter, the flag stays set.
- R6: `irq` is high exactly when the pending flag and the enable are both set. Clearing the enable masks `irq` but keeps the flag. Word 3 reports the flag in bit 0 and the `irq` level in bit 1.
- R7: Writing word 4 stores the throttle, which reads back from word 4. The same write clears the counter to zero, and a wrap in that cycle is dropped.
- R8: With a throttle of zero, the counter stays at zero and the pending flag is never set, even while enabled.
- R9: Word 6 returns the parameter PERIOD_NS, and writes to word 6 have no effect.
- R10: Words 7 and 11, and every other index not listed above, read as zero, and writes to them change no register.
- R11: A read strobe at a clock edge loads `rd_data` with the addressed word as it stood just before that edge. `rd_data` holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read strobe, one clock per read |
| addr | input | ADDR_W (4) | Word index |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data |
| irq_ack | input | 1 | Acknowledge; clears the pending flag |
| irq | output | 1 | Level interrupt request |

## Verification
Three throttle patterns are used.
- A throttle of zero separates "halted" from "wrapping at once".
- A throttle of three is sampled one clock before and at the expected request. A second request is also checked, so an off-by-one period or a one-shot flag is caught.
- A throttle of one, loaded by the disable, reload and enable sequence, shows that the new period takes effect.

A throttle of one hundred is read while running and again after a rewrite. This separates the counting behaviour from the clearing on reload and on disable.

Two acknowledge cases are tried. An acknowledge on a wrap clock must leave the flag set, while an acknowledge on an idle clock must clear it. Finally, toggling the enable with the flag held shows that masking and pending are kept apart.

// File: rtl/pit_pkg.sv
// Package: shared constants for the periodic interval timer.
// Assumes a word-addressed window of at most 16 words.
package pit_pkg;
    localparam int unsigned W_CTRL   = 0;
    localparam int unsigned W_STAT   = 3;
    localparam int unsigned W_THROT  = 4;
    localparam int unsigned W_COUNT  = 5;
    localparam int unsigned W_PERIOD = 6;
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned STAT_PND_BIT = 0;
    localparam int unsigned STAT_IRQ_BIT = 1;
endpackage

// File: rtl/pit_ctrl_regs.sv
// Module: pit_ctrl_regs
// Holds the enable bit and the throttle word, and decodes the write strobe.
// Assumes one write per strobe clock; a write to any other word is dropped here.
module pit_ctrl_regs
    import pit_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              enable,
    output logic [DATA_W-1:0] throttle,
    output logic              throttle_wr
);
    logic ctrl_hit;

    // Decode which writable word the strobe targets.
    always_comb begin
        ctrl_hit    = wr_en && (addr == ADDR_W'(W_CTRL));
        throttle_wr = wr_en && (addr == ADDR_W'(W_THROT));
    end

    // Store the enable bit and the throttle value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            throttle <= '0;
        end else begin
            if (ctrl_hit)    enable   <= wr_data[CTRL_EN_BIT];
            if (throttle_wr) throttle <= wr_data;
        end
    end
endmodule

// File: rtl/pit_count_core.sv
// Module: pit_count_core
// Counts bus clocks up to the throttle value, then wraps and latches a pending flag.
// Assumes the throttle and enable come from registers, so both are stable within a clock.
module pit_count_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] throttle,
    input  logic             throttle_wr,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] count,
    output logic             pending
);
    logic running;
    logic at_end;

    // The timer runs only when enabled with a nonzero throttle.
    always_comb begin
        running = enable && (throttle != '0);
        at_end  = running && (count == throttle);
    end

    // Advance, wrap or clear the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (throttle_wr || !running) count <= '0;
        else if (at_end)                count <= '0;
        else                            count <= count + 1'b1;
    end

    // Set the pending flag on a wrap; a set in the same clock wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pending <= 1'b0;
        else if (at_end && !throttle_wr)  pending <= 1'b1;
        else if (irq_ack)                 pending <= 1'b0;
    end
endmodule

// File: rtl/pit_read_port.sv
// Module: pit_read_port
// Selects the addressed word and registers it on a read strobe.
// Assumes every index without a defined word reads as zero.
module pit_read_port
    import pit_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PERIOD_NS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              enable,
    input  logic [DATA_W-1:0] throttle,
    input  logic [DATA_W-1:0] count,
    input  logic              pending,
    input  logic              irq,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] PERIOD_WORD = DATA_W'(PERIOD_NS);

    logic [DATA_W-1:0] sel_word;

    // Build the word at the current index.
    always_comb begin
        sel_word = '0;
        case (int'(addr))
            W_CTRL:   sel_word[CTRL_EN_BIT] = enable;
            W_STAT: begin
                sel_word[STAT_PND_BIT] = pending;
                sel_word[STAT_IRQ_BIT] = irq;
            end
            W_THROT:  sel_word = throttle;
            W_COUNT:  sel_word = count;
            W_PERIOD: sel_word = PERIOD_WORD;
            default:  sel_word = '0;
        endcase
    end

    // Capture the selected word on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_word;
    end
endmodule

// File: rtl/pit_timer.sv
// Module: pit_timer (top)
// Bus-mapped periodic interval timer with a level interrupt and an acknowledge input.
// Assumes a synchronous active-low reset and single-clock strobes.
module pit_timer #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PERIOD_NS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_ack,
    output logic              irq
);
    logic              enable;
    logic              throttle_wr;
    logic              pending;
    logic [DATA_W-1:0] throttle;
    logic [DATA_W-1:0] count;

    pit_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .enable(enable), .throttle(throttle), .throttle_wr(throttle_wr)
    );

    pit_count_core #(.CNT_W(DATA_W)) i_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .throttle(throttle),
        .throttle_wr(throttle_wr), .irq_ack(irq_ack), .count(count), .pending(pending)
    );

    // The request is the pending flag masked by the enable.
    always_comb irq = pending && enable;

    pit_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERIOD_NS(PERIOD_NS)) i_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .enable(enable),
        .throttle(throttle), .count(count), .pending(pending), .irq(irq), .rd_data(rd_data)
    );
endmodule

// File: rtl/pit_timer_chk.sv
// Module: pit_timer_chk
// Temporal checks on the timer, attached to the top module by bind.
module pit_timer_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_ack,
    input logic              enable,
    input logic [DATA_W-1:0] throttle,
    input logic [DATA_W-1:0] count,
    input logic              pending
);
    // R3: the counter stays within the throttle while running.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && throttle != '0) |-> (count <= throttle));

    // R4: a wrap without a concurrent throttle write sets the pending flag.
    a_r4_wrap_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && throttle != '0 && count == throttle && !(wr_en && addr == ADDR_W'(4)))
        |=> (pending && count == '0));

    // R5: an acknowledge outside a wrap clears the flag.
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && count != throttle) |=> !pending);

    // R8: a zero throttle keeps the counter at zero.
    a_r8_zero_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle == '0) |=> (count == '0));

    // R2: a write that clears the enable leaves the counter at zero.
    a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && !wr_data[0]) |=> ##1 (count == '0));

    // R7: a throttle write clears the counter.
    a_r7_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(4)) |=> (count == '0));
endmodule

bind pit_timer pit_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .irq_ack(irq_ack), .enable(enable), .throttle(throttle), .count(count),
    .pending(pending)
);

// File: tb/test_pit_timer.sv
module test_pit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_ack = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit rd_seen = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    pit_timer #(.ADDR_W(4), .DATA_W(32), .PERIOD_NS(10)) i_pit_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_ack(irq_ack), .irq(irq)
    );

    always #5 clk = ~clk;

    // Track which edges carried a read strobe.
    always @(posedge clk) rd_seen <= rst_n && rd_en;

    // Monitor: pop the expected word and compare it with the read data.
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected read: actual %h expected none", rd_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s read: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    // Driver: one write, starting and ending on a falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: one read, whose expected word goes to the scoreboard.
    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq: actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_irq(1'b0, "R1");
        rd(0, 0, "R1"); rd(3, 0, "R1"); rd(4, 0, "R1"); rd(5, 0, "R1");
        // R9 period constant
        rd(6, 10, "R9"); wr(6, 32'h5); rd(6, 10, "R9");
        // R10 zero words
        wr(7, 32'hFFFF_FFFF); wr(11, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
        rd(7, 0, "R10"); rd(11, 0, "R10"); rd(1, 0, "R10"); rd(9, 0, "R10");
        rd(4, 0, "R10"); rd(0, 0, "R10");
        // R8 zero throttle halts
        wr(4, 0); wr(0, 1);
        repeat (20) @(negedge clk);
        chk_irq(1'b0, "R8"); rd(5, 0, "R8"); rd(3, 0, "R8");
        // R3 / R7 counting and reload
        wr(0, 0); wr(4, 100); rd(4, 100, "R7");
        wr(0, 1);
        repeat (5) @(negedge clk);
        rd(5, 5, "R3");
        wr(4, 100); rd(5, 0, "R7");
        rd(0, 1, "R2");
        wr(0, 0);
        repeat (3) @(negedge clk);
        rd(5, 0, "R2"); rd(0, 0, "R2");
        // R4 throttle 3
        wr(4, 3); wr(0, 1);
        chk_irq(1'b0, "R4");
        repeat (3) @(negedge clk);
        chk_irq(1'b0, "R4");
        @(negedge clk);
        chk_irq(1'b1, "R4");
        rd(3, 3, "R6");
        @(negedge clk); @(negedge clk);
        irq_ack = 1'b1;                   // ack lands on the wrap clock
        @(negedge clk); irq_ack = 1'b0;
        chk_irq(1'b1, "R5");
        irq_ack = 1'b1;                   // ack on an idle clock
        @(negedge clk); irq_ack = 1'b0;
        chk_irq(1'b0, "R5");
        @(negedge clk); @(negedge clk);
        chk_irq(1'b0, "R4");
        @(negedge clk);
        chk_irq(1'b1, "R4");
        // R6 masking keeps the flag
        wr(0, 0);
        chk_irq(1'b0, "R6");
        rd(3, 1, "R6"); rd(5, 0, "R2");
        wr(0, 1);
        chk_irq(1'b1, "R6");
        irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk_irq(1'b0, "R5");
        // Retarget: disable, reload 1, enable
        wr(0, 0); wr(4, 1); wr(0, 1);
        chk_irq(1'b0, "R4");
        @(negedge clk);
        chk_irq(1'b0, "R4");
        @(negedge clk);
        chk_irq(1'b1, "R4");
        wr(0, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule